// File: doc/BRIEF.md
# Scanline Fetch Phase Tracker

This block follows a graphics chip through the fixed sequence of fetch groups that make up one rendered scanline. Address line 13 is high for the name-table and attribute reads of a tile group and low for its two pattern reads, so each group produces one rising edge of that line. The block samples the line only at the falling edge of the read strobe and counts the 0-to-1 transitions of that sampled level. From the running count it reports which part of the line is being fetched: background tiles, sprite pattern slots, the two prefetch tiles for the next line, or the closing pair of dummy name-table reads.

Neighbouring logic uses the phase code to choose between sprite and background bank sets, and uses the tile index to locate a horizontal split point. A one-cycle line-start pulse from the scanline boundary detector restarts the count. A bus-idle level, asserted during blanking when the line does not toggle in its usual pattern, holds the count at zero. Both raw bus inputs are asynchronous and pass through synchronizers before they are used.

Top module: `fetch_phase_tracker`

## Requirements
- R1: After reset, edge_count is 0, phase is 0 (background), and bg_tile and spr_slot are 0.
- R2: Each rise of the qualified address-13 level (the level sampled at read-strobe falling edges) raises edge_count by exactly one. Several consecutive high reads count once.
- R3: Changes of address line 13 that are not captured by a falling edge of the read strobe do not change edge_count.
- R4: For edge_count 1 to 32, phase is 0 and bg_tile equals edge_count minus 1. For edge_count 0, phase is 0 and bg_tile is 0.
- R5: For edge_count 33 to 40, phase is 1 (sprite), spr_slot equals edge_count minus 33, and bg_tile is 0. Outside this range spr_slot is 0.
- R6: For edge_count 41 and 42, phase is 2 (prefetch). For edge_count 43, phase is 3 (dummy). In both cases bg_tile and spr_slot are 0.
- R7: Once edge_count reaches 43, further edges leave it at 43 and phase at 3 until a restart.
- R8: A line_start pulse makes edge_count 0 on the next clock. The next high read after the pulse counts as the first edge.
- R9: While bus_idle is high, edge_count stays 0 and no edges are counted. After bus_idle is released, the first high read counts as edge 1.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a13_raw | input | 1 | Asynchronous graphics address line 13 |
| rd_n_raw | input | 1 | Asynchronous active-low read strobe |
| line_start | input | 1 | One-cycle pulse at a scanline boundary |
| bus_idle | input | 1 | High while the graphics bus is idle |
| edge_count | output | 6 | Qualified edges seen since the last restart, saturating at 43 |
| phase | output | 2 | 0 background, 1 sprite, 2 prefetch, 3 dummy |
| bg_tile | output | 5 | Background tile index, valid in phase 0 |
| spr_slot | output | 3 | Sprite slot index, valid in phase 1 |

## Verification
The hardest states to reach are the ends of the sequence: the boundaries between phases at counts 32/33 and 40/41, and saturation past 43. Reaching them takes a full line of correctly ordered fetch groups. The stimulus models each group as two high reads followed by two low reads, and drives a complete line of 43 groups with a check after every group, then adds extra groups to push past the saturation point. Separate scenarios toggle the address line while the strobe stays high, and restart the count in the middle of a line or under bus idle.

// File: rtl/fetch_phase_tracker.sv
module fetch_phase_tracker #(
  parameter int BG_TILES    = 32,
  parameter int SPR_SLOTS   = 8,
  parameter int PRE_TILES   = 2,
  parameter int DUMMY_TILES = 1,
  parameter int SYNC_STAGES = 2,
  localparam int TOTAL = BG_TILES + SPR_SLOTS + PRE_TILES + DUMMY_TILES,
  localparam int CW    = $clog2(TOTAL + 1),
  localparam int BW    = $clog2(BG_TILES),
  localparam int SW    = $clog2(SPR_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a13_raw,
  input  logic          rd_n_raw,
  input  logic          line_start,
  input  logic          bus_idle,
  output logic [CW-1:0] edge_count,
  output logic [1:0]    phase,
  output logic [BW-1:0] bg_tile,
  output logic [SW-1:0] spr_slot
);
  localparam logic [CW-1:0] SPR_FIRST = CW'(BG_TILES + 1);
  localparam logic [CW-1:0] SPR_LAST  = CW'(BG_TILES + SPR_SLOTS);
  localparam logic [CW-1:0] PRE_LAST  = CW'(BG_TILES + SPR_SLOTS + PRE_TILES);
  localparam logic [CW-1:0] BG_LAST   = CW'(BG_TILES);
  localparam logic [CW-1:0] CNT_MAX   = CW'(TOTAL);

  logic [SYNC_STAGES-1:0] a13_sync, rd_sync;
  logic rd_prev, a13_lvl;
  logic [CW-1:0] cnt;

  wire a13_s   = a13_sync[SYNC_STAGES-1];
  wire rd_s    = rd_sync[SYNC_STAGES-1];
  wire rd_fall = rd_prev & ~rd_s;
  wire rise    = rd_fall & a13_s & ~a13_lvl;
  wire restart = line_start | bus_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a13_sync <= '0;
      rd_sync  <= '1;
      rd_prev  <= 1'b1;
      a13_lvl  <= 1'b0;
      cnt      <= '0;
    end else begin
      a13_sync <= {a13_sync[SYNC_STAGES-2:0], a13_raw};
      rd_sync  <= {rd_sync[SYNC_STAGES-2:0], rd_n_raw};
      rd_prev  <= rd_s;
      if (restart) begin
        a13_lvl <= 1'b0;
        cnt     <= '0;
      end else begin
        if (rd_fall) a13_lvl <= a13_s;
        if (rise && cnt != CNT_MAX) cnt <= cnt + CW'(1);
      end
    end
  end

  assign edge_count = cnt;

  always_comb begin
    phase    = 2'd0;
    bg_tile  = '0;
    spr_slot = '0;
    if (cnt <= BG_LAST) begin
      if (cnt != '0) bg_tile = BW'(cnt - CW'(1));
    end else if (cnt <= SPR_LAST) begin
      phase    = 2'd1;
      spr_slot = SW'(cnt - SPR_FIRST);
    end else if (cnt <= PRE_LAST) begin
      phase = 2'd2;
    end else begin
      phase = 2'd3;
    end
  end
endmodule

module fetch_phase_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       bus_idle,
  input logic [5:0] edge_count,
  input logic [1:0] phase,
  input logic [2:0] spr_slot
);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !bus_idle) |=>
      (edge_count == $past(edge_count) || edge_count == $past(edge_count) + 6'd1));
  // R7
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_count == 6'd43 && !line_start && !bus_idle) |=> edge_count == 6'd43);
  // R8
  line_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> edge_count == 6'd0);
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |=> edge_count == 6'd0);
  // R5
  sprite_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd1 |-> (edge_count >= 6'd33 && edge_count <= 6'd40));
  // R5
  slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd1 |-> spr_slot == 3'd0);
  // R6
  dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 |-> edge_count == 6'd43);
endmodule

bind fetch_phase_tracker fetch_phase_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .bus_idle(bus_idle),
  .edge_count(edge_count), .phase(phase), .spr_slot(spr_slot)
);

// File: tb/sim_fetch_phase_tracker.sv
module sim_fetch_phase_tracker;
  logic clk = 0, rst_n = 0, a13_raw = 0, rd_n_raw = 1, line_start = 0, bus_idle = 0;
  logic [5:0] edge_count;
  logic [1:0] phase;
  logic [4:0] bg_tile;
  logic [2:0] spr_slot;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  fetch_phase_tracker u0 (
    .clk(clk), .rst_n(rst_n), .a13_raw(a13_raw), .rd_n_raw(rd_n_raw),
    .line_start(line_start), .bus_idle(bus_idle), .edge_count(edge_count),
    .phase(phase), .bg_tile(bg_tile), .spr_slot(spr_slot)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input int c);
    int ep, eb, es;
    ep = (c <= 32) ? 0 : (c <= 40) ? 1 : (c <= 42) ? 2 : 3;
    eb = (c >= 1 && c <= 32) ? c - 1 : 0;
    es = (c >= 33 && c <= 40) ? c - 33 : 0;
    checks++;
    if (edge_count != c || phase != ep || bg_tile != eb || spr_slot != es) begin
      errors++;
      $display("FAIL %s: count/phase/tile/slot actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               req, edge_count, phase, bg_tile, spr_slot, c, ep, eb, es);
    end
  endtask

  task automatic one_read(input logic lvl);
    a13_raw = lvl; rd_n_raw = 1; wait_cyc(3);
    rd_n_raw = 0; wait_cyc(3);
    rd_n_raw = 1;
  endtask

  task automatic group();
    one_read(1); one_read(1); one_read(0); one_read(0);
    wait_cyc(4);
  endtask

  task automatic pulse_start();
    line_start = 1; wait_cyc(1); line_start = 0; wait_cyc(1);
  endtask

  task automatic t_reset();
    expect_state("R1", 0);
  endtask

  task automatic t_full_line();
    pulse_start();
    for (int g = 1; g <= 43; g++) begin
      group();
      if (g <= 32) expect_state("R4", g);
      else if (g <= 40) expect_state("R5", g);
      else expect_state("R6", g);
    end
  endtask

  task automatic t_saturate();
    for (int g = 0; g < 3; g++) begin
      group();
      expect_state("R7", 43);
    end
  endtask

  task automatic t_restart_midline();
    pulse_start();
    expect_state("R8", 0);
    for (int g = 0; g < 10; g++) group();
    expect_state("R2", 10);
    pulse_start();
    expect_state("R8", 0);
    group();
    expect_state("R8", 1);
  endtask

  task automatic t_glitch();
    pulse_start();
    group(); group();
    for (int i = 0; i < 8; i++) begin
      a13_raw = ~a13_raw; wait_cyc(3);
    end
    a13_raw = 0; wait_cyc(4);
    expect_state("R3", 2);
    one_read(1); one_read(1); one_read(1); wait_cyc(4);
    expect_state("R2", 3);
  endtask

  task automatic t_idle();
    pulse_start();
    for (int g = 0; g < 5; g++) group();
    expect_state("R2", 5);
    bus_idle = 1; wait_cyc(2);
    expect_state("R9", 0);
    for (int g = 0; g < 4; g++) group();
    expect_state("R9", 0);
    bus_idle = 0; wait_cyc(2);
    group();
    expect_state("R9", 1);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(2);
    t_reset();
    t_full_line();
    t_saturate();
    t_restart_midline();
    t_glitch();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule